// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks through a multi-register memory transfer one word at a time. A request gives a base address, a 16-bit list saying which registers take part, one of four walking modes and a flag asking for the base register to be updated. The sequencer then issues one transfer per accepted handshake. Each transfer carries a register index and a word address. Whatever the mode, registers always come out in ascending index order at ascending addresses, so the lowest-numbered register lands at the lowest address.

The two decrementing modes first count the listed registers. From that count they work out where the block starts, and then they also walk upward. When the last transfer has been accepted, the block pulses a completion flag. At the same moment it presents the updated base value, which is qualified by a write-back strobe when the request asked for one. Decoding the instruction, the register file and the memory port belong to the surrounding logic.

Top module: `ldm_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `xferValid`, `done`, `wbValid` and `busy` are all low.
- R2: A request is captured on a clock edge where `startValid` is high and the block is idle. With n equal to the number of set bits in `regMask`, the first address depends on `mode`: 0 (increment after) gives base, 1 (increment before) gives base+4, 2 (decrement after) gives base-4n+4, and 3 (decrement before) gives base-4n. Changing the inputs after capture has no effect on the sequence.
- R3: Transfers carry the set bits of the captured list in ascending index order. Each transfer's address is 4 bytes above the previous one, so transfer k sits at the first address plus 4k.
- R4: From the cycle after capture until the last transfer is accepted, `xferValid` stays high. While `xferReady` is low, `xferReg` and `xferAddr` hold steady. Exactly one transfer is consumed per cycle in which valid and ready are both high.
- R5: `wbValue` during `done` equals base+4n for modes 0 and 1, and base-4n for modes 2 and 3, using modulo 2^32 arithmetic.
- R6: `wbValid` is high only in the `done` cycle, and only when `wbEn` was high at capture.
- R7: `done` is high for exactly one cycle. That cycle is the one right after the last accepted transfer, and `xferValid` is low during it.
- R8: An empty list issues no transfers, and `done` rises in the cycle right after capture.
- R9: A `startValid` pulse arriving while `busy` is high is ignored. The running sequence continues unchanged, and the block is idle again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Request strobe, taken only while idle |
| baseAddr | input | 32 | Base register value |
| regMask | input | 16 | Register list, bit i selects register i |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wbEn | input | 1 | Request base update at the end |
| xferValid | output | 1 | A transfer is offered |
| xferReady | input | 1 | Consumer accepts the offered transfer |
| xferReg | output | 4 | Register index of the offered transfer |
| xferAddr | output | 32 | Word address of the offered transfer |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Base update requested, coincident with done |
| wbValue | output | 32 | Updated base value |
| busy | output | 1 | A request is in progress |

## Verification
Because the request passes through one register stage, the first transfer is due in the cycle after the capture edge. Every later transfer is due in the cycle after the previous handshake, and `done` comes one cycle after the last handshake, or one cycle after capture for an empty list. The bench drives and samples on the falling edge. It keeps a running expected transfer index and a remaining-list copy, and it checks valid, register and address in each of these cycles. When `done` appears, it checks that the previous cycle held the final handshake. A final sample in the following cycle confirms that the block has gone back to idle.

// File: rtl/ldm_seq_pkg.sv
`timescale 1ns/1ps
package ldm_seq_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } walkMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request, compute start and end values
    logic advance;  // retire the current transfer
  } seqCtrl_t;

endpackage

// File: rtl/ldm_seq_popcnt.sv
`timescale 1ns/1ps
module ldm_seq_popcnt #(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/ldm_seq_prio.sv
`timescale 1ns/1ps
module ldm_seq_prio #(
  parameter int WIDTH = 16,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] lowIdx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    lowIdx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) lowIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ldm_seq_dpath.sv
`timescale 1ns/1ps
module ldm_seq_dpath
  import ldm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_COUNT  = 16,
  parameter int STEP_BYTES = 4,
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1,
  localparam int CNT_W = $clog2(REG_COUNT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtrl_t             ctrl,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [REG_COUNT-1:0] regMask,
  input  logic [1:0]           mode,
  input  logic                 wbEnIn,
  output logic                 listEmpty,
  output logic                 lastPending,
  output logic [IDX_W-1:0]     curReg,
  output logic [ADDR_W-1:0]    curAddr,
  output logic [ADDR_W-1:0]    wbValue,
  output logic                 wbEnHeld
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

  logic [REG_COUNT-1:0] pend;
  logic [REG_COUNT-1:0] pendDrop;
  logic [CNT_W-1:0]     setCount;
  logic [ADDR_W-1:0]    span;
  logic [ADDR_W-1:0]    startAddr;
  logic [ADDR_W-1:0]    endBase;

  ldm_seq_popcnt #(.WIDTH(REG_COUNT)) u_cnt (
    .vec   (regMask),
    .count (setCount)
  );

  ldm_seq_prio #(.WIDTH(REG_COUNT)) u_prio (
    .vec    (pend),
    .lowIdx (curReg)
  );

  assign span      = ADDR_W'(setCount) * STEP;
  assign listEmpty = (regMask == '0);
  assign pendDrop  = pend & (pend - REG_COUNT'(1));
  assign lastPending = (pend != '0) && (pendDrop == '0);

  // Start and final base; every mode ends up walking upward
  always_comb begin
    case (walkMode_e'(mode))
      MODE_INC_AFTER: begin
        startAddr = baseAddr;
        endBase   = baseAddr + span;
      end
      MODE_INC_BEFORE: begin
        startAddr = baseAddr + STEP;
        endBase   = baseAddr + span;
      end
      MODE_DEC_AFTER: begin
        startAddr = baseAddr - span + STEP;
        endBase   = baseAddr - span;
      end
      default: begin
        startAddr = baseAddr - span;
        endBase   = baseAddr - span;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      curAddr  <= '0;
      wbValue  <= '0;
      wbEnHeld <= 1'b0;
    end else if (ctrl.load) begin
      pend     <= regMask;
      curAddr  <= startAddr;
      wbValue  <= endBase;
      wbEnHeld <= wbEnIn;
    end else if (ctrl.advance) begin
      pend     <= pendDrop;
      curAddr  <= curAddr + STEP;
    end
  end

endmodule

// File: rtl/ldm_seq_ctrl.sv
`timescale 1ns/1ps
module ldm_seq_ctrl
  import ldm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startValid,
  input  logic     listEmpty,
  input  logic     lastPending,
  input  logic     xferReady,
  output seqCtrl_t ctrl,
  output logic     xferValid,
  output logic     done,
  output logic     busy
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    xferValid = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          ctrl.load = 1'b1;
          nextState = listEmpty ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        xferValid = 1'b1;
        if (xferReady) begin
          ctrl.advance = 1'b1;
          if (lastPending) nextState = ST_FIN;
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ldm_seq.sv
`timescale 1ns/1ps
module ldm_seq
  import ldm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_COUNT  = 16,
  parameter int STEP_BYTES = 4,
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [REG_COUNT-1:0] regMask,
  input  logic [1:0]           mode,
  input  logic                 wbEn,
  output logic                 xferValid,
  input  logic                 xferReady,
  output logic [IDX_W-1:0]     xferReg,
  output logic [ADDR_W-1:0]    xferAddr,
  output logic                 done,
  output logic                 wbValid,
  output logic [ADDR_W-1:0]    wbValue,
  output logic                 busy
);

  seqCtrl_t ctrl;
  logic     listEmpty;
  logic     lastPending;
  logic     wbEnHeld;

  ldm_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .listEmpty   (listEmpty),
    .lastPending (lastPending),
    .xferReady   (xferReady),
    .ctrl        (ctrl),
    .xferValid   (xferValid),
    .done        (done),
    .busy        (busy)
  );

  ldm_seq_dpath #(
    .ADDR_W     (ADDR_W),
    .REG_COUNT  (REG_COUNT),
    .STEP_BYTES (STEP_BYTES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .baseAddr    (baseAddr),
    .regMask     (regMask),
    .mode        (mode),
    .wbEnIn      (wbEn),
    .listEmpty   (listEmpty),
    .lastPending (lastPending),
    .curReg      (xferReg),
    .curAddr     (xferAddr),
    .wbValue     (wbValue),
    .wbEnHeld    (wbEnHeld)
  );

  assign wbValid = done & wbEnHeld;

endmodule

// File: rtl/ldm_seq_chk.sv
`timescale 1ns/1ps
module ldm_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4,
  parameter int IDX_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferValid,
  input logic              xferReady,
  input logic [IDX_W-1:0]  xferReg,
  input logic [ADDR_W-1:0] xferAddr,
  input logic              done,
  input logic              wbValid,
  input logic              busy
);

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && xferReady) |=> (!xferValid ||
      (xferAddr == $past(xferAddr) + ADDR_W'(STEP_BYTES) && xferReg > $past(xferReg))));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferReady) |=> (xferValid && $stable(xferAddr) && $stable(xferReg)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !xferValid);

  p_wb_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

  p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> busy);

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind ldm_seq ldm_seq_chk #(
  .ADDR_W     (ADDR_W),
  .STEP_BYTES (STEP_BYTES),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .xferValid (xferValid),
  .xferReady (xferReady),
  .xferReg   (xferReg),
  .xferAddr  (xferAddr),
  .done      (done),
  .wbValid   (wbValid),
  .busy      (busy)
);

// File: tb/sim_ldm_seq.sv
`timescale 1ns/1ps
module sim_ldm_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startValid;
  logic [31:0] baseAddr;
  logic [15:0] regMask;
  logic [1:0]  mode;
  logic        wbEn;
  logic        xferValid;
  logic        xferReady;
  logic [3:0]  xferReg;
  logic [31:0] xferAddr;
  logic        done;
  logic        wbValid;
  logic [31:0] wbValue;
  logic        busy;

  int vecs = 0;
  int errs = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2.5 clk = ~clk;

  ldm_seq u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .baseAddr(baseAddr),
    .regMask(regMask), .mode(mode), .wbEn(wbEn), .xferValid(xferValid),
    .xferReady(xferReady), .xferReg(xferReg), .xferAddr(xferAddr),
    .done(done), .wbValid(wbValid), .wbValue(wbValue), .busy(busy)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runSeq(input logic [1:0] m, input logic [15:0] mask,
                        input logic [31:0] base, input bit wb,
                        input bit rndReady, input bit inject);
    int n;
    logic [31:0] firstAddr, wbExp;
    logic [15:0] rem;
    int k;
    bit prevLastHs, finished;
    int expReg;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(mask[i]);
    case (m)
      2'd0: firstAddr = base;
      2'd1: firstAddr = base + 32'd4;
      2'd2: firstAddr = base - 32'(4 * n) + 32'd4;
      default: firstAddr = base - 32'(4 * n);
    endcase
    wbExp = (m[1]) ? base - 32'(4 * n) : base + 32'(4 * n);

    @(negedge clk);
    startValid = 1'b1; regMask = mask; baseAddr = base; mode = m; wbEn = wb;
    @(negedge clk);
    // R2: scramble inputs after capture
    startValid = 1'b0; regMask = ~mask; baseAddr = ~base; mode = ~m; wbEn = ~wb;
    rem = mask; k = 0; prevLastHs = 0; finished = 0;
    for (int cyc = 0; cyc < 100 && !finished; cyc++) begin
      xferReady  = 1'b0;
      startValid = (inject && cyc == 1);  // R9: stray request while busy
      lfsr = nextRand(lfsr);
      if (done) begin
        if (n == 0)
          check(cyc == 0, "R8", "done latency on empty list", 32'(cyc), 32'd0);
        else
          check(prevLastHs && k == n, "R7", "done after last handshake", 32'(k), 32'(n));
        check(!xferValid, "R7", "valid during done", 32'(xferValid), 32'd0);
        check(wbValid == wb, "R6", "wbValid", 32'(wbValid), 32'(wb));
        if (wb) check(wbValue == wbExp, "R5", "wbValue", wbValue, wbExp);
        finished = 1;
      end else if (xferValid) begin
        prevLastHs = 0;
        if (k >= n) begin
          check(0, "R3", "extra transfer", 32'(xferReg), 32'hFFFF_FFFF);
        end else begin
          expReg = 0;
          for (int i = 15; i >= 0; i--) if (rem[i]) expReg = i;
          check(xferReg == 4'(expReg), "R3", "register order", 32'(xferReg), 32'(expReg));
          check(xferAddr == firstAddr + 32'(4 * k), "R2", "transfer address",
                xferAddr, firstAddr + 32'(4 * k));
          xferReady = rndReady ? lfsr[3] : 1'b1;
          if (xferReady) begin
            rem[expReg] = 1'b0;
            k++;
            prevLastHs = (k == n);
          end
        end
      end else begin
        check(0, "R4", "valid dropped mid-sequence", 32'd0, 32'd1);
        prevLastHs = 0;
      end
      @(negedge clk);
    end
    xferReady = 1'b0; startValid = 1'b0;
    check(finished, "R7", "sequence completion", 32'(finished), 32'd1);
    check(!busy && !xferValid && !done, "R9", "idle after done",
          {29'd0, busy, xferValid, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] fixedMasks [5];
    rstN = 1'b0; startValid = 1'b0; baseAddr = '0; regMask = '0;
    mode = '0; wbEn = 1'b0; xferReady = 1'b0;
    fixedMasks[0] = 16'h0000; fixedMasks[1] = 16'h0001; fixedMasks[2] = 16'h8000;
    fixedMasks[3] = 16'hFFFF; fixedMasks[4] = 16'hA5A5;
    repeat (3) @(negedge clk);
    check(!xferValid && !done && !wbValid && !busy, "R1", "outputs in reset",
          {28'd0, xferValid, done, wbValid, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!xferValid && !done && !wbValid && !busy, "R1", "outputs after reset",
          {28'd0, xferValid, done, wbValid, busy}, 32'd0);

    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 5; f++) begin
        runSeq(2'(m), fixedMasks[f], 32'h0000_1000, f[0], 1'b0, 1'b0);
        runSeq(2'(m), fixedMasks[f], 32'h0000_0008, ~f[0], 1'b1, f != 0);
      end
      for (int r = 0; r < 30; r++) begin
        lfsr = nextRand(lfsr);
        lfsr = nextRand(lfsr);
        runSeq(2'(m), lfsr[15:0], {lfsr[31:2], 2'b00}, lfsr[20], r[0],
               (lfsr[15:0] != 0) && r[1]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule